// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

This block arbitrates the interrupt requests of an 8051-class core. There are ten request sources. Each one has its own enable bit and a two-bit priority, and one global enable gates all of them. Three serial flags (transmit done, receive done, SPI transfer done) are merged into one source. The two timer-2 flags are merged into another. Every cycle the block picks the armed source with the highest level. When several sources share that level, a fixed polling order decides between them. The winner is granted only if its level is strictly above the highest level already in service.

A grant produces a one-cycle acknowledge pulse. The pulse carries the source index, the granted level and the vector address. The flag logic around the block uses the index to clear flags that hardware clears. The block records the granted level as in service. A return-from-interrupt strobe retires the highest level in service, so nested service unwinds in the right order. A separate registered wake output tells the power manager that one of the two sources allowed to leave power-down is pending.

Top module: `prio_intc`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `ackPulse` and `wakeUp` are 0 and no level is in service.
- R2: The level of source i is {`prioHi[i]`,`prioLo[i]`}: 3 is the highest and 0 the lowest. Of the armed sources, one at the highest present level wins.
- R3: Among armed sources at the same level, the lowest index wins. Indices in polling order: 0 ext0, 1 brown-out, 2 timer 0, 3 ext1, 4 timer 1, 5 PCA, 6 ext2, 7 ext3, 8 serial/SPI, 9 timer 2.
- R4: The vector for indices 0..9 is, in order, 0x03, 0x4B, 0x0B, 0x13, 0x1B, 0x33, 0x3B, 0x43, 0x23, 0x2B. It is placed on `vecAddr` with the acknowledge.
- R5: Source 8 requests when any of `serTxFlag`, `serRxFlag` or `spiDoneFlag` is set. Source 9 requests when `tmr2OvfFlag` or `tmr2ExtFlag` is set.
- R6: A source is armed only when its request, `srcEn[i]` and `globalEn` are all 1. With `globalEn` at 0, no grant happens, whatever the individual enables are.
- R7: A winner is granted only if its level is strictly above the highest level in service, or if no level is in service. The grant shows in the cycle after the request is sampled: `ackPulse` is high for one cycle with `ackIdx`, `ackLvl` and `vecAddr`. The granted level is marked in service.
- R8: A cycle with `retiStb` high clears the highest level in service. When no level is in service, `retiStb` has no effect.
- R9: `wakeUp` is registered. It is 1 in the cycle after `powerDown`, `globalEn` and either (`ext0Req` and `srcEn[0]`) or (`ext1Req` and `srcEn[3]`) are all high. The other sources never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ext0Req | input | 1 | External request 0 (index 0) |
| brownoutReq | input | 1 | Supply-droop request (index 1) |
| tmr0Req | input | 1 | Timer 0 overflow (index 2) |
| ext1Req | input | 1 | External request 1 (index 3) |
| tmr1Req | input | 1 | Timer 1 overflow (index 4) |
| pcaReq | input | 1 | Capture/compare array request (index 5) |
| ext2Req | input | 1 | External request 2 (index 6) |
| ext3Req | input | 1 | External request 3 (index 7) |
| serTxFlag | input | 1 | Serial transmit done (index 8) |
| serRxFlag | input | 1 | Serial receive done (index 8) |
| spiDoneFlag | input | 1 | SPI transfer done (index 8) |
| tmr2OvfFlag | input | 1 | Timer 2 overflow (index 9) |
| tmr2ExtFlag | input | 1 | Timer 2 external event (index 9) |
| srcEn | input | 10 | Per-source enable, bit i for index i |
| prioHi | input | 10 | Upper priority bit per source |
| prioLo | input | 10 | Lower priority bit per source |
| globalEn | input | 1 | Master enable |
| retiStb | input | 1 | Return-from-interrupt strobe |
| powerDown | input | 1 | Core is in power-down |
| ackPulse | output | 1 | One-cycle grant pulse |
| ackIdx | output | 4 | Index of the granted source |
| ackLvl | output | 2 | Level of the grant |
| vecAddr | output | 16 | Vector address of the grant |
| wakeUp | output | 1 | Registered wake request |

## Verification
The bench builds the block with its default parameters. These are a 16-bit vector with base offset 3 and step 8, which gives exactly the vector set of R4, with ten sources and four levels. At this size every level, every polling position and the full four-deep nesting stack can be reached in a few thousand cycles. The reference model keeps in-service levels as a queue, so preemption, blocked same-level requests and strobes that arrive with an empty stack are all compared on every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC  = 10;
  localparam int NUM_RAW  = 13;
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int SLOT_W   = 4;
  // sources able to leave power-down: ext0 (0) and ext1 (3)
  localparam logic [NUM_SRC-1:0] WAKE_MASK = 10'b00_0000_1001;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic grant;
    lvl_t lvl;
  } ctrl_stb_t;

  // vector slot per polling index; address = offset + step * slot
  function automatic logic [SLOT_W-1:0] slotOf(idx_t i);
    case (i)
      4'd0:    slotOf = 4'd0;
      4'd1:    slotOf = 4'd9;
      4'd2:    slotOf = 4'd1;
      4'd3:    slotOf = 4'd2;
      4'd4:    slotOf = 4'd3;
      4'd5:    slotOf = 4'd6;
      4'd6:    slotOf = 4'd7;
      4'd7:    slotOf = 4'd8;
      4'd8:    slotOf = 4'd4;
      4'd9:    slotOf = 4'd5;
      default: slotOf = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
  parameter int W  = 10,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [PW-1:0] pos
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        pos   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_OFS  = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_RAW-1:0] rawReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] prioHi,
  input  logic [NUM_SRC-1:0] prioLo,
  input  logic               globalEn,
  input  logic               powerDown,
  input  ctrl_stb_t          stb,
  output logic               candValid,
  output idx_t               candIdx,
  output lvl_t               candLvl,
  output logic               ackPulse,
  output idx_t               ackIdx,
  output lvl_t               ackLvl,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               wakeUp
);
  localparam int DIRECT_N = NUM_SRC - 2;

  logic [NUM_SRC-1:0] srcReq;
  logic [NUM_SRC-1:0] armed;
  lvl_t               srcLvl [NUM_SRC];
  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvlHit;
  logic [NUM_LVL-1:0] lvlAny;
  logic [VEC_W-1:0]   candVec;

  // merge shared flags into the two combined sources
  assign srcReq[DIRECT_N-1:0] = rawReq[DIRECT_N-1:0];
  assign srcReq[DIRECT_N]     = |rawReq[DIRECT_N+2:DIRECT_N];
  assign srcReq[DIRECT_N+1]   = |rawReq[NUM_RAW-1:DIRECT_N+3];
  assign armed = srcReq & srcEn & {NUM_SRC{globalEn}};

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign lvlHit[l][i] = armed[i] && (srcLvl[i] == lvl_t'(l));
    end
    assign lvlAny[l] = |lvlHit[l];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvlmap
    assign srcLvl[i] = {prioHi[i], prioLo[i]};
  end

  always_comb begin
    candLvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvlAny[l]) candLvl = lvl_t'(l);
    end
  end

  intc_first_set #(.W(NUM_SRC), .PW(IDX_W)) u_pick (
    .bits (lvlHit[candLvl]),
    .found(candValid),
    .pos  (candIdx)
  );

  assign candVec = VEC_W'(VEC_OFS) + VEC_W'(VEC_STEP) * VEC_W'(slotOf(candIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPulse <= 1'b0;
      ackIdx   <= '0;
      ackLvl   <= '0;
      vecAddr  <= '0;
      wakeUp   <= 1'b0;
    end else begin
      ackPulse <= stb.grant;
      if (stb.grant) begin
        ackIdx  <= candIdx;
        ackLvl  <= stb.lvl;
        vecAddr <= candVec;
      end
      wakeUp <= powerDown && globalEn && |(srcReq & srcEn & WAKE_MASK);
    end
  end

  p_global_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !ackPulse);
  p_wake_needs_pd_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> $past(powerDown));
  p_ack_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.grant |=> (ackLvl == $past({prioHi[candIdx], prioLo[candIdx]})));
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      candValid,
  input  lvl_t      candLvl,
  input  logic      retiStb,
  output ctrl_stb_t stb
);
  logic [NUM_LVL-1:0] inService;
  logic [NUM_LVL-1:0] clearMask;
  logic [NUM_LVL-1:0] setMask;
  logic               topValid;
  lvl_t               topLvl;

  always_comb begin
    topLvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (inService[l]) topLvl = lvl_t'(l);
    end
  end
  assign topValid = |inService;

  assign stb.grant = candValid && (!topValid || (candLvl > topLvl));
  assign stb.lvl   = candLvl;

  always_comb begin
    clearMask = '0;
    setMask   = '0;
    if (retiStb && topValid) clearMask[topLvl] = 1'b1;
    if (stb.grant)           setMask[candLvl]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inService <= '0;
    else       inService <= (inService & ~clearMask) | setMask;
  end

  p_grant_adds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.grant && !(retiStb && topValid)) |=>
      ($countones(inService) == $past($countones(inService)) + 1));
  p_reti_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retiStb && topValid && !stb.grant) |=>
      ($countones(inService) + 1 == $past($countones(inService))));
  p_top_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    inService[NUM_LVL-1] |-> !stb.grant);
  p_idle_reti_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!topValid && !stb.grant) |=> (inService == '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_OFS  = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ext0Req,
  input  logic               brownoutReq,
  input  logic               tmr0Req,
  input  logic               ext1Req,
  input  logic               tmr1Req,
  input  logic               pcaReq,
  input  logic               ext2Req,
  input  logic               ext3Req,
  input  logic               serTxFlag,
  input  logic               serRxFlag,
  input  logic               spiDoneFlag,
  input  logic               tmr2OvfFlag,
  input  logic               tmr2ExtFlag,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] prioHi,
  input  logic [NUM_SRC-1:0] prioLo,
  input  logic               globalEn,
  input  logic               retiStb,
  input  logic               powerDown,
  output logic               ackPulse,
  output logic [IDX_W-1:0]   ackIdx,
  output logic [LVL_W-1:0]   ackLvl,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               wakeUp
);
  logic [NUM_RAW-1:0] rawReq;
  ctrl_stb_t          stb;
  logic               candValid;
  idx_t               candIdx;
  lvl_t               candLvl;

  assign rawReq = {tmr2ExtFlag, tmr2OvfFlag, spiDoneFlag, serRxFlag, serTxFlag,
                   ext3Req, ext2Req, pcaReq, tmr1Req, ext1Req, tmr0Req,
                   brownoutReq, ext0Req};

  intc_datapath #(.VEC_W(VEC_W), .VEC_OFS(VEC_OFS), .VEC_STEP(VEC_STEP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rawReq   (rawReq),
    .srcEn    (srcEn),
    .prioHi   (prioHi),
    .prioLo   (prioLo),
    .globalEn (globalEn),
    .powerDown(powerDown),
    .stb      (stb),
    .candValid(candValid),
    .candIdx  (candIdx),
    .candLvl  (candLvl),
    .ackPulse (ackPulse),
    .ackIdx   (ackIdx),
    .ackLvl   (ackLvl),
    .vecAddr  (vecAddr),
    .wakeUp   (wakeUp)
  );

  intc_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .candValid(candValid),
    .candLvl  (candLvl),
    .retiStb  (retiStb),
    .stb      (stb)
  );
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [12:0] raw = '0;
  logic [9:0] srcEn = '0, prioHi = '0, prioLo = '0;
  logic globalEn = 1'b0, retiStb = 1'b0, powerDown = 1'b0;
  logic ackPulse, wakeUp;
  logic [3:0] ackIdx;
  logic [1:0] ackLvl;
  logic [15:0] vecAddr;

  int checks = 0, errors = 0;
  string curTag = "R1 reset";

  always #5ns clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rstN(rstN),
    .ext0Req(raw[0]), .brownoutReq(raw[1]), .tmr0Req(raw[2]), .ext1Req(raw[3]),
    .tmr1Req(raw[4]), .pcaReq(raw[5]), .ext2Req(raw[6]), .ext3Req(raw[7]),
    .serTxFlag(raw[8]), .serRxFlag(raw[9]), .spiDoneFlag(raw[10]),
    .tmr2OvfFlag(raw[11]), .tmr2ExtFlag(raw[12]),
    .srcEn(srcEn), .prioHi(prioHi), .prioLo(prioLo), .globalEn(globalEn),
    .retiStb(retiStb), .powerDown(powerDown),
    .ackPulse(ackPulse), .ackIdx(ackIdx), .ackLvl(ackLvl), .vecAddr(vecAddr),
    .wakeUp(wakeUp)
  );

  // ---------------- reference model ----------------
  int   stack[$];
  logic eAck = 1'b0, eWake = 1'b0;
  int   eIdx = 0, eLvl = 0, eVec = 0;
  int   top, best, bestLvl;
  logic [9:0] merged;

  function automatic int vecOf(int i);
    case (i)
      0: return 'h03;  1: return 'h4B;  2: return 'h0B;  3: return 'h13;
      4: return 'h1B;  5: return 'h33;  6: return 'h3B;  7: return 'h43;
      8: return 'h23;  default: return 'h2B;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stack.delete();
      eAck  = 1'b0;
      eWake = 1'b0;
    end else begin
      merged = {raw[11] | raw[12], raw[8] | raw[9] | raw[10], raw[7:0]};
      top = (stack.size() > 0) ? stack[stack.size() - 1] : -1;
      best = -1;
      bestLvl = -1;
      for (int l = 3; l >= 0; l--) begin
        for (int i = 0; i < 10; i++) begin
          if (best < 0 && globalEn && srcEn[i] && merged[i]
              && (int'({prioHi[i], prioLo[i]}) == l)) begin
            best = i;
            bestLvl = l;
          end
        end
      end
      eAck = (best >= 0) && (bestLvl > top);
      if (eAck) begin
        eIdx = best;
        eLvl = bestLvl;
        eVec = vecOf(best);
      end
      if (retiStb && stack.size() > 0) void'(stack.pop_back());
      if (eAck) stack.push_back(bestLvl);
      eWake = powerDown && globalEn && ((raw[0] && srcEn[0]) || (raw[3] && srcEn[3]));
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %0d exp %0d", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(ackPulse === eAck, "ackPulse", int'(ackPulse), int'(eAck));
    if (eAck) begin
      check(int'(ackIdx) == eIdx, "ackIdx", int'(ackIdx), eIdx);
      check(int'(ackLvl) == eLvl, "ackLvl", int'(ackLvl), eLvl);
      check(int'(vecAddr) == eVec, "vecAddr R4", int'(vecAddr), eVec);
    end
    check(wakeUp === eWake, "wakeUp R9", int'(wakeUp), int'(eWake));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic reti();
    retiStb = 1'b1;
    tick();
    retiStb = 1'b0;
  endtask

  function automatic int rawBit(int src);
    if (src < 8) return src;
    return (src == 8) ? 8 : 11;
  endfunction

  task automatic setLvl(int src, int l);
    prioHi[src] = l[1];
    prioLo[src] = l[0];
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired R1 act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    curTag = "R1 reset";
    tick();
    check(ackPulse === 1'b0 && wakeUp === 1'b0, "reset outputs R1",
          int'(ackPulse), 0);
    @(negedge clk);
    rstN = 1'b1;
    srcEn = '1;
    globalEn = 1'b1;
    tick();
    check(ackPulse === 1'b0, "after release R1", int'(ackPulse), 0);

    // R4: each source alone gets its own vector
    curTag = "R4 vectors";
    for (int s = 0; s < 10; s++) begin
      raw[rawBit(s)] = 1'b1;
      tick();
      check(int'(vecAddr) == vecOf(s), "direct vector R4", int'(vecAddr), vecOf(s));
      raw = '0;
      reti();
    end

    // R3: all pending at one level, served in polling order
    curTag = "R3 polling order";
    raw = 13'h1FFF;
    for (int s = 0; s < 10; s++) begin
      tick();
      check(int'(ackIdx) == s, "poll index R3", int'(ackIdx), s);
      tick();  // held requests at the same level do not regrant (R7)
      if (s == 8) raw[10:8] = '0;
      else if (s == 9) raw[12:11] = '0;
      else raw[s] = 1'b0;
      reti();
    end

    // R2: the highest level wins over polling order
    curTag = "R2 level select";
    for (int s = 0; s < 10; s++) setLvl(s, s % 4);
    raw = 13'h1FFF;
    tick();
    check(int'(ackIdx) == 3 && int'(ackLvl) == 3, "top level R2", int'(ackIdx), 3);
    raw = '0;
    reti();
    prioHi = '0; prioLo = '0;
    setLvl(9, 2); setLvl(0, 1);
    raw[0] = 1'b1; raw[12] = 1'b1;
    tick();
    check(int'(ackIdx) == 9, "timer2 above ext0 R2", int'(ackIdx), 9);
    raw = '0;
    reti(); reti(); tick();
    prioHi = '0; prioLo = '0;

    // R5: merged flags
    curTag = "R5 merged flags";
    for (int b = 8; b < 13; b++) begin
      raw[b] = 1'b1;
      tick();
      check(int'(ackIdx) == ((b < 11) ? 8 : 9), "merged index R5", int'(ackIdx),
            (b < 11) ? 8 : 9);
      raw = '0;
      reti();
    end

    // R6: masking
    curTag = "R6 enables";
    globalEn = 1'b0;
    raw = 13'h1FFF;
    tick(); tick();
    check(ackPulse === 1'b0, "global off R6", int'(ackPulse), 0);
    globalEn = 1'b1;
    srcEn = 10'b10_0000_0000;
    tick();
    check(int'(ackIdx) == 9, "only enabled R6", int'(ackIdx), 9);
    raw = '0;
    srcEn = '1;
    reti();

    // R7 / R8: nesting
    curTag = "R7 nesting";
    setLvl(4, 1); setLvl(6, 1); setLvl(5, 2); setLvl(0, 3); setLvl(1, 3);
    raw[4] = 1'b1;
    tick();
    check(ackPulse === 1'b1 && int'(ackIdx) == 4, "first grant R7", int'(ackIdx), 4);
    raw[4] = 1'b0; raw[6] = 1'b1;
    tick();
    check(ackPulse === 1'b0, "same level blocked R7", int'(ackPulse), 0);
    raw[5] = 1'b1;
    tick();
    check(int'(ackIdx) == 5, "preempt R7", int'(ackIdx), 5);
    raw[5] = 1'b0; raw[0] = 1'b1;
    tick();
    raw[0] = 1'b0; raw[1] = 1'b1;
    tick();
    check(ackPulse === 1'b0, "level 3 not preempted R7", int'(ackPulse), 0);
    raw[1] = 1'b0;
    curTag = "R8 return";
    reti();
    reti();
    reti();  // level 1 retires; ext2 at level 1 still pending
    tick();
    check(int'(ackIdx) == 6, "pending after unwind R8", int'(ackIdx), 6);
    raw = '0;
    reti();
    reti(); reti();  // nothing in service: no effect
    raw[2] = 1'b1;
    tick();
    check(ackPulse === 1'b1, "empty return harmless R8", int'(ackPulse), 1);
    raw = '0;
    reti();
    prioHi = '0; prioLo = '0;

    // R9: wake-up
    curTag = "R9 wake";
    powerDown = 1'b1;
    raw[2] = 1'b1; raw[6] = 1'b1;
    tick();
    check(wakeUp === 1'b0, "non-wake source R9", int'(wakeUp), 0);
    raw = '0; reti(); reti();
    raw[3] = 1'b1;
    tick();
    check(wakeUp === 1'b1, "ext1 wakes R9", int'(wakeUp), 1);
    srcEn[3] = 1'b0;
    tick();
    check(wakeUp === 1'b0, "disabled ext1 R9", int'(wakeUp), 0);
    raw = '0; srcEn = '1; reti();
    raw[0] = 1'b1;
    tick();
    raw = '0;
    powerDown = 1'b0;
    reti();

    // random mix against the model
    curTag = "R7 random";
    for (int c = 0; c < 4000; c++) begin
      raw       = 13'($urandom) & 13'($urandom) & 13'($urandom);
      srcEn     = 10'($urandom) | 10'($urandom);
      prioHi    = 10'($urandom);
      prioLo    = 10'($urandom);
      globalEn  = ($urandom % 8) != 0;
      retiStb   = ($urandom % 3) == 0;
      powerDown = ($urandom % 4) == 0;
      tick();
    end
    retiStb = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule